// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is a combinational 8-bit arithmetic and logic unit with a small registered status-flag file. Each cycle it takes an operation code and two 8-bit operands (a left and a right operand). It produces an 8-bit result and the next value of five status flags: negative, overflow, half-carry, zero and carry. The current flags that feed the arithmetic come from the block's own flag register. That register takes the new flag values on a rising clock edge only while the flag-write enable is high.

The operations are:
- add and subtract, both using the incoming carry;
- compare, which does not use the incoming carry;
- bitwise AND, OR and XOR;
- increment and decrement;
- shift left and logical shift right;
- rotate left and rotate right through the carry;
- nibble exchange.

Each operation updates only the flags it defines, and the other flags keep their registered values. Single-operand operations act on the left operand only. The enclosing datapath decides where the result goes and when the flags are committed.

Top module: `alu8_flags`

## Requirements
- R1: Operation code 0 (add) gives result = (lhs + rhs + C) mod 256. C is set when the unsigned total exceeds 255, and N, Z, H and V are updated as well.
- R2: Operation code 1 (subtract) gives result = (lhs - rhs + C - 1) mod 256. C is set when that unsigned difference is not negative, so C = 1 means no borrow. N, Z, H and V are updated as well.
- R3: For add and subtract, V is set exactly when the signed value of the operation, with the carry term included, lies outside -128..127.
- R4: H is set on add when (lhs mod 16) + (rhs mod 16) + C > 15. H is set on subtract when (lhs mod 16) - (rhs mod 16) + C - 1 < 0.
- R5: Operation code 2 (compare) shows lhs - rhs on the result port without using C. It sets C = 1 when unsigned lhs >= rhs, updates N and Z, and leaves V and H unchanged.
- R6: Operation codes 3, 4, 5, 6 and 7 give lhs AND rhs, lhs OR rhs, lhs XOR rhs, lhs + 1 and lhs - 1 (all modulo 256). They update only N and Z.
- R7: Operation code 8 shifts lhs left and operation code 9 shifts lhs right. In both cases the bit shifted out goes to C and the vacated bit is 0. Only N, Z and C change.
- R8: Operation codes 10 and 11 rotate lhs left and right through C as a 9-bit value. The bit shifted out goes to C, and the old C enters the vacated end. Only N, Z and C change.
- R9: Operation code 12 swaps the two nibbles of lhs and updates only N and Z.
- R10: For operation codes 0 to 12, N equals bit 7 of the result and Z is 1 exactly when the result is 0.
- R11: The flags port is packed as bit 4 = N, bit 3 = V, bit 2 = H, bit 1 = Z, bit 0 = C. The flag register loads flags_next on a rising clock edge when flag_we is 1, and holds otherwise.
- R12: While rst_n is low the flag register is all zeros.
- R13: Operation codes 13 to 15 pass lhs to the result and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code |
| lhs | input | 8 | Left operand |
| rhs | input | 8 | Right operand |
| flag_we | input | 1 | Commit flags_next into the flag register at the next rising edge |
| result | output | 8 | Combinational operation result |
| flags_next | output | 5 | Combinational next flag values (N,V,H,Z,C) |
| flags | output | 5 | Registered flags (N,V,H,Z,C) that feed the operations |

## Verification
The only internal state is the flag register. A wrong stored flag shows up on the flags port in the cycle after the write edge. It also changes the result of the next carry-dependent operation, such as add, subtract or a rotate, during that same cycle. A wrongly kept or wrongly written flag (for example, a compare that disturbs V, or a logic operation that changes C) is therefore visible within one cycle at flags_next and within two cycles in an arithmetic result. The bench carries the expected flag state across long sequences, both with and without commits, so that a corrupted flag is caught by whichever later operation reads it.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 4;
    localparam int FLAG_W = 5;

    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_H = 2;
    localparam int FB_V = 3;
    localparam int FB_N = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADC = 4'd0,
        OP_SBC = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_INC = 4'd6,
        OP_DEC = 4'd7,
        OP_ASL = 4'd8,
        OP_LSR = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11,
        OP_XCN = 4'd12
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic h;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            flg;
    } alu_out_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = alu8_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    input  logic         use_cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hout,
    output logic         vout
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [H:0]   lo_sum;
    logic [W:0]   full_sum;

    always_comb begin
        // subtract is addition of the complement; carry out then means no borrow
        b_eff    = sub ? ~b : b;
        c_eff    = use_cin ? cin : 1'b1;
        lo_sum   = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c_eff};
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum      = full_sum[W-1:0];
        cout     = full_sum[W];
        // on subtract the half flag marks a borrow out of the low nibble
        hout     = sub ? ~lo_sum[H] : lo_sum[H];
        vout     = (a[W-1] == b_eff[W-1]) && (full_sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  alu_op_e       op,
    output logic [W-1:0]  res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_INC:  res = a + W'(1);
            OP_DEC:  res = a - W'(1);
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int H = W / 2;

    logic [W-1:0] swapped;

    for (genvar i = 0; i < H; i++) begin : g_swap
        assign swapped[i]     = a[i+H];
        assign swapped[i+H]   = a[i];
    end

    always_comb begin
        unique case (op)
            OP_ASL: begin res = {a[W-2:0], 1'b0}; cout = a[W-1]; end
            OP_LSR: begin res = {1'b0, a[W-1:1]}; cout = a[0];   end
            OP_ROL: begin res = {a[W-2:0], cin};  cout = a[W-1]; end
            OP_ROR: begin res = {cin, a[W-1:1]};  cout = a[0];   end
            OP_XCN: begin res = swapped;          cout = cin;    end
            default: begin res = a;               cout = cin;    end
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              flag_we,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_next,
    output logic [FLAG_W-1:0] flags
);
    alu_op_e  op;
    flags_t   flags_q;
    alu_out_t out_d;

    logic [DATA_W-1:0] as_sum, lg_res, sh_res;
    logic              as_c, as_h, as_v, sh_c;
    logic              is_sub, use_cin;

    assign op      = alu_op_e'(op_sel);
    assign is_sub  = (op == OP_SBC) || (op == OP_CMP);
    assign use_cin = (op != OP_CMP);

    alu8_addsub #(.W(DATA_W)) u_addsub (
        .a       (lhs),
        .b       (rhs),
        .cin     (flags_q.c),
        .sub     (is_sub),
        .use_cin (use_cin),
        .sum     (as_sum),
        .cout    (as_c),
        .hout    (as_h),
        .vout    (as_v)
    );

    alu8_logic #(.W(DATA_W)) u_logic (
        .a   (lhs),
        .b   (rhs),
        .op  (op),
        .res (lg_res)
    );

    alu8_shift #(.W(DATA_W)) u_shift (
        .a    (lhs),
        .cin  (flags_q.c),
        .op   (op),
        .res  (sh_res),
        .cout (sh_c)
    );

    always_comb begin
        out_d.res = lhs;
        out_d.flg = flags_q;
        case (op)
            OP_ADC, OP_SBC: begin
                out_d.res   = as_sum;
                out_d.flg.c = as_c;
                out_d.flg.h = as_h;
                out_d.flg.v = as_v;
            end
            OP_CMP: begin
                out_d.res   = as_sum;
                out_d.flg.c = as_c;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                out_d.res = lg_res;
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR, OP_XCN: begin
                out_d.res   = sh_res;
                out_d.flg.c = sh_c;
            end
            default: ;
        endcase
        if (op_sel <= OP_W'(OP_XCN)) begin
            out_d.flg.n = out_d.res[DATA_W-1];
            out_d.flg.z = (out_d.res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else if (flag_we)
            flags_q <= out_d.flg;
    end

    assign result     = out_d.res;
    assign flags_next = out_d.flg;
    assign flags      = flags_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] lhs,
    input logic [DATA_W-1:0] rhs,
    input logic              flag_we,
    input logic [DATA_W-1:0] result,
    input logic [FLAG_W-1:0] flags_next,
    input logic [FLAG_W-1:0] flags
);
    logic is_logic;
    assign is_logic = (op_sel >= OP_W'(OP_AND)) && (op_sel <= OP_W'(OP_DEC));

    // R11
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> $stable(flags));
    // R11
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> flags == $past(flags_next));
    // R5
    a_r5_cmp_keeps_vh: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == OP_W'(OP_CMP) |-> flags_next[FB_V] == flags[FB_V] && flags_next[FB_H] == flags[FB_H]);
    // R6
    a_r6_logic_keeps_cvh: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |-> flags_next[FB_C] == flags[FB_C] && flags_next[FB_V] == flags[FB_V]
                     && flags_next[FB_H] == flags[FB_H]);
    // R7
    a_r7_shl_out: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == OP_W'(OP_ASL) |-> flags_next[FB_C] == lhs[DATA_W-1] && result[0] == 1'b0);
    // R10
    a_r10_nz: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel <= OP_W'(OP_XCN) |-> flags_next[FB_N] == result[DATA_W-1]
                                    && flags_next[FB_Z] == (result == '0));
    // R13
    a_r13_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel > OP_W'(OP_XCN) |-> result == lhs && flags_next == flags);

    // R12
    always @(negedge clk) begin
        if (!rst_n)
            a_r12_reset_zero: assert (flags == '0);
    end
endmodule

bind alu8_flags alu8_flags_chk chk (.*);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] lhs = '0, rhs = '0;
    logic       flag_we = 1'b0;
    logic [7:0] result;
    logic [4:0] flags_next, flags;

    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alu8_flags uut (.*);

    typedef struct packed {
        logic [7:0] res;
        logic [4:0] nf;
        logic [4:0] cf;
    } item_t;

    item_t sbq[$];
    string tagq[$];
    logic [4:0] mflags = '0;

    function automatic int sgn(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R1";  1: return "R2";  2: return "R5";
            3, 4, 5, 6, 7: return "R6";
            8, 9: return "R7";  10, 11: return "R8";  12: return "R9";
            default: return "R13";
        endcase
    endfunction

    // flag bits: 4=N 3=V 2=H 1=Z 0=C
    task automatic model(input int op, input int l, input int r, input logic [4:0] f,
                         output int res, output logic [4:0] nf);
        int c, t, s;
        c = int'(f[0]);
        nf = f;
        res = l;
        case (op)
            0: begin t = l + r + c; res = t & 255; nf[0] = t > 255;
                     s = sgn(l) + sgn(r) + c; nf[3] = (s < -128) || (s > 127);
                     nf[2] = ((l & 15) + (r & 15) + c) > 15; end
            1: begin t = l - r + c - 1; res = t & 255; nf[0] = t >= 0;
                     s = sgn(l) - sgn(r) + c - 1; nf[3] = (s < -128) || (s > 127);
                     nf[2] = ((l & 15) - (r & 15) + c - 1) < 0; end
            2: begin t = l - r; res = t & 255; nf[0] = t >= 0; end
            3: res = l & r;
            4: res = l | r;
            5: res = l ^ r;
            6: res = (l + 1) & 255;
            7: res = (l + 255) & 255;
            8: begin res = (l * 2) & 255; nf[0] = l >= 128; end
            9: begin res = l / 2; nf[0] = (l % 2) == 1; end
            10: begin res = (l * 2 + c) & 255; nf[0] = l >= 128; end
            11: begin res = l / 2 + c * 128; nf[0] = (l % 2) == 1; end
            12: res = (l % 16) * 16 + l / 16;
            default: res = l;
        endcase
        if (op <= 12) begin
            nf[4] = res >= 128;
            nf[1] = res == 0;
        end
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_op(input int op, input int l, input int r, input logic we, input string tag);
        int res;
        logic [4:0] nf;
        item_t it;
        @(negedge clk);
        op_sel = 4'(op); lhs = 8'(l); rhs = 8'(r); flag_we = we;
        model(op, l, r, mflags, res, nf);
        it.res = 8'(res); it.nf = nf; it.cf = mflags;
        sbq.push_back(it);
        tagq.push_back(tag);
        if (we) mflags = nf;
    endtask

    // monitor: compares combinational outputs and registered flags
    initial begin
        item_t it;
        string tg;
        forever begin
            @(negedge clk);
            #2;
            if (sbq.size() != 0) begin
                it = sbq.pop_front();
                tg = tagq.pop_front();
                chk(tg, "result", int'(result), int'(it.res));
                chk(tg, "flags_next", int'(flags_next), int'(it.nf));
                chk("R11", "flags", int'(flags), int'(it.cf));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 chk("R12", "flags in reset", int'(flags), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #2 chk("R12", "flags after reset", int'(flags), 0);

        do_op(0, 8'h7F, 8'h01, 1, "R3");   // 80, V=1 H=1 N=1
        do_op(8, 8'h80, 8'h00, 1, "R7");   // 00, C=1 Z=1
        do_op(0, 8'hFF, 8'h00, 1, "R4");   // 00 with C in, C=1 H=1
        do_op(1, 8'h05, 8'h03, 1, "R2");   // 02, C=1 (no borrow)
        do_op(1, 8'h00, 8'h01, 1, "R4");   // FF, C=0 H=1
        do_op(1, 8'h80, 8'h01, 1, "R3");   // 7E with C=0, V=1
        do_op(2, 8'h42, 8'h42, 1, "R5");   // Z=1 C=1, V kept
        do_op(2, 8'h10, 8'h20, 1, "R5");   // C=0 N=1
        do_op(10, 8'h81, 8'h00, 1, "R8");  // 02, C=1
        do_op(11, 8'h01, 8'h00, 1, "R8");  // 80, C=1
        do_op(9, 8'h01, 8'h00, 1, "R7");   // 00, C=1
        do_op(12, 8'hA5, 8'h00, 1, "R9");  // 5A
        do_op(6, 8'hFF, 8'h00, 1, "R10");  // 00 Z
        do_op(7, 8'h00, 8'h00, 1, "R10");  // FF N
        do_op(3, 8'hF0, 8'h0F, 1, "R6");
        do_op(4, 8'h30, 8'h03, 1, "R6");
        do_op(5, 8'hFF, 8'hFF, 1, "R6");
        do_op(0, 8'h80, 8'h80, 0, "R11");  // not committed: flags held
        do_op(13, 8'h3C, 8'h00, 1, "R13");
        do_op(15, 8'h00, 8'hFF, 1, "R13");

        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 15);
            do_op(op, $urandom_range(0, 255), $urandom_range(0, 255),
                  logic'($urandom_range(0, 3) != 0), tag_of(op));
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule